// File: doc/BRIEF.md
# Serial Register Access Port

This block is a four-wire serial slave that lets a host controller read and write a bank of 128 byte-wide registers. The host pulls the select line low and clocks in 16-bit frames. Each frame carries a 7-bit register address, one direction flag and 8 data bits. All fields go least significant bit first. The block turns each frame into a single access on a simple register-file port. It presents the address, and it either pulses a write strobe with the assembled byte or fetches a byte to shift out on the serial data output. The output enable goes high only while a read frame returns data, so other devices can share the bus lines.

All logic runs on the serial clock. Input bits are sampled on rising edges and read data is launched on falling edges. Raising the select line, or holding the device reset low, clears the block asynchronously, so the next selection always starts at address bit 0. Frames may follow one another without a gap under one selection. A control state machine steps through three states:

- `FS_ADDR` collects the address bits.
- `FS_FLAG` takes the direction flag.
- `FS_DATA` moves the data byte.

The transitions are as follows:

- `FS_ADDR` goes to `FS_FLAG` after the seventh address bit.
- `FS_FLAG` goes to `FS_DATA` on the flag edge.
- `FS_DATA` returns to `FS_ADDR` after the eighth data bit.
- Any state returns to `FS_ADDR` on deselect or reset.

Top module: `spi_regport`

## Requirements
- R1: A frame is 16 rising serial clock edges. Edges 1 to 7 carry address bits 0 to 6 in that order, edge 8 carries the direction flag, and edges 9 to 16 carry data bits 0 to 7. `reg_addr` holds the frame's address unchanged from the 8th edge through the 16th.
- R2: A flag value of 0 selects a write and a value of 1 selects a read. A read frame never asserts `reg_wr_en`.
- R3: In a write frame, `reg_wr_en` is high only in the clock period that ends with the 16th rising edge. During that period `reg_wr_data` equals the eight data bits of the frame, so the register file commits on that edge.
- R4: In a read frame, `reg_rd_data` is taken at the falling edge after the 8th rising edge. Data bit k is driven on `sdo` after the falling edge that follows rising edge 8+k. Register changes after the capture do not alter the bits shifted out in that frame.
- R5: `sdo_oe` is 1 only in a read frame, from the falling edge after the 8th rising edge up to the 16th rising edge. At all other times it is 0.
- R6: While `cs_n` stays low, frames follow back to back. The edge after a frame's 16th edge is address bit 0 of the next frame, and each write frame gives exactly one write strobe.
- R7: Raising `cs_n` before the 16th rising edge abandons the frame. No write takes place, `sdo_oe` drops at once, and the next selection starts at address bit 0.
- R8: While `rst_n` is 0, the block stays idle whatever `cs_n` and the serial clock do. `reg_wr_en` and `sdo_oe` stay 0.
- R9: After reset with `cs_n` high, `reg_wr_en` is 0 and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Device reset, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low; its high level clears the frame logic |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data from the host, sampled on rising edges |
| sdo | output | 1 | Serial read data, launched on falling edges |
| sdo_oe | output | 1 | Tri-state enable for `sdo` (1 = drive) |
| reg_addr | output | 7 | Register address of the current frame |
| reg_wr_en | output | 1 | Write strobe, sampled by the register file on the rising serial clock edge |
| reg_wr_data | output | 8 | Write byte, valid while `reg_wr_en` is high |
| reg_rd_data | input | 8 | Byte returned by the register file for `reg_addr` |

## Verification
The bench sweeps every address with back-to-back write frames and then back-to-back read frames under a single selection. A bit-order or frame-length error would therefore show up as corrupted or shifted bytes. It aborts a write frame after every possible bit count from 1 to 15. A design that commits early, or that does not clear its counter on deselect, would alter the target register or misalign the following frame. It also flips the register during a read data phase, which catches a design that reads the register late instead of taking a snapshot. It holds reset low during a complete frame to confirm that nothing is written.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    typedef enum logic [1:0] {
        FS_ADDR = 2'd0,
        FS_FLAG = 2'd1,
        FS_DATA = 2'd2
    } frame_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              sclk,
    input  logic              arst,
    input  logic              sdi,
    output logic [ADDR_W-1:0] addr,
    output logic              rd_flag,
    output logic [DATA_W-2:0] data_lo,
    output logic              in_data,
    output logic              data_first,
    output logic              data_last
);
    localparam int CNT_W = $clog2(max_of(ADDR_W, DATA_W));
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-2:0] data_q;
    logic              flag_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FS_ADDR: begin
                if (cnt_q == ADDR_LAST) begin
                    state_d = FS_FLAG;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            FS_FLAG: begin
                state_d = FS_DATA;
                cnt_d   = '0;
            end
            FS_DATA: begin
                if (cnt_q == DATA_LAST) begin
                    state_d = FS_ADDR;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = FS_ADDR;
                cnt_d   = '0;
            end
        endcase
    end

    // state register and bit capture
    always_ff @(posedge sclk or posedge arst) begin
        if (arst) begin
            state_q <= FS_ADDR;
            cnt_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            unique case (state_q)
                FS_ADDR: addr_q <= {sdi, addr_q[ADDR_W-1:1]};
                FS_FLAG: flag_q <= sdi;
                FS_DATA: begin
                    if (cnt_q != DATA_LAST) begin
                        data_q <= {sdi, data_q[DATA_W-2:1]};
                    end
                end
                default: flag_q <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        addr       = addr_q;
        rd_flag    = flag_q;
        data_lo    = data_q;
        in_data    = (state_q == FS_DATA);
        data_first = (state_q == FS_DATA) && (cnt_q == '0);
        data_last  = (state_q == FS_DATA) && (cnt_q == DATA_LAST);
    end

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              sclk,
    input  logic              arst,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] load_data,
    output logic              bit_out,
    output logic              launched
);
    logic [DATA_W-2:0] rest_q;
    logic              bit_q;
    logic              live_q;

    always_ff @(negedge sclk or posedge arst) begin
        if (arst) begin
            rest_q <= '0;
            bit_q  <= 1'b0;
            live_q <= 1'b0;
        end else if (load) begin
            bit_q  <= load_data[0];
            rest_q <= load_data[DATA_W-1:1];
            live_q <= 1'b1;
        end else if (shift) begin
            bit_q  <= rest_q[0];
            rest_q <= {1'b0, rest_q[DATA_W-2:1]};
        end else begin
            live_q <= 1'b0;
        end
    end

    always_comb begin
        bit_out  = bit_q;
        launched = live_q;
    end

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    input  logic [DATA_W-1:0] reg_rd_data
);
    logic              sel_rst;
    logic [ADDR_W-1:0] addr;
    logic              rd_flag;
    logic [DATA_W-2:0] data_lo;
    logic              in_data;
    logic              data_first;
    logic              data_last;
    logic              tx_bit;
    logic              tx_live;
    logic              rd_phase;

    assign sel_rst = cs_n | ~rst_n;

    spi_frame_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .sclk      (sclk),
        .arst      (sel_rst),
        .sdi       (sdi),
        .addr      (addr),
        .rd_flag   (rd_flag),
        .data_lo   (data_lo),
        .in_data   (in_data),
        .data_first(data_first),
        .data_last (data_last)
    );

    assign rd_phase = in_data & rd_flag;

    spi_tx_shifter #(
        .DATA_W(DATA_W)
    ) u_tx (
        .sclk     (sclk),
        .arst     (sel_rst),
        .load     (data_first & rd_flag),
        .shift    (rd_phase & ~data_first),
        .load_data(reg_rd_data),
        .bit_out  (tx_bit),
        .launched (tx_live)
    );

    always_comb begin
        reg_addr    = addr;
        reg_wr_data = {sdi, data_lo};
        reg_wr_en   = data_last & ~rd_flag & ~sel_rst;
        sdo         = tx_bit;
        sdo_oe      = tx_live & rd_phase & ~sel_rst;
    end

endmodule

// File: rtl/spi_regport_checker.sv
module spi_regport_checker #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input logic              sclk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sdi,
    input logic              sdo_oe,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr
);
    localparam int FRAME = ADDR_W + 1 + DATA_W;
    localparam int CW    = $clog2(FRAME);

    logic          chk_rst;
    logic [CW-1:0] edge_cnt;
    logic          seen_rd;

    assign chk_rst = cs_n | ~rst_n;

    always_ff @(posedge sclk or posedge chk_rst) begin
        if (chk_rst) begin
            edge_cnt <= '0;
            seen_rd  <= 1'b0;
        end else begin
            edge_cnt <= (edge_cnt == CW'(FRAME - 1)) ? '0 : edge_cnt + 1'b1;
            if (edge_cnt == CW'(ADDR_W)) seen_rd <= sdi;
        end
    end

    assert_write_on_last_edge_R3: assert property (@(posedge sclk) disable iff (chk_rst)
        reg_wr_en |-> (edge_cnt == CW'(FRAME - 1)) && !seen_rd);

    assert_write_due_R2: assert property (@(posedge sclk) disable iff (chk_rst)
        ((edge_cnt == CW'(FRAME - 1)) && !seen_rd) |-> reg_wr_en);

    assert_single_strobe_R6: assert property (@(posedge sclk) disable iff (chk_rst)
        reg_wr_en |=> !reg_wr_en);

    assert_oe_window_R5: assert property (@(posedge sclk) disable iff (chk_rst)
        sdo_oe |-> (edge_cnt >= CW'(ADDR_W + 1)) && seen_rd);

    assert_oe_driven_R4: assert property (@(posedge sclk) disable iff (chk_rst)
        ((edge_cnt >= CW'(ADDR_W + 1)) && seen_rd) |-> sdo_oe);

    assert_addr_held_R1: assert property (@(posedge sclk) disable iff (chk_rst)
        (edge_cnt >= CW'(ADDR_W + 1)) |-> $stable(reg_addr));

    always_comb begin
        if (cs_n === 1'b1) begin
            assert_deselect_quiet_R7: assert (!sdo_oe && !reg_wr_en);
        end
        if (rst_n === 1'b0) begin
            assert_reset_idle_R8: assert (!sdo_oe && !reg_wr_en);
        end
    end

endmodule

bind spi_regport spi_regport_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sdi      (sdi),
    .sdo_oe   (sdo_oe),
    .reg_wr_en(reg_wr_en),
    .reg_addr (reg_addr)
);

// File: tb/spi_regport_test.sv
`timescale 1ns/1ps
module spi_regport_test;
    logic       rst_n = 1'b0;
    logic       cs_n  = 1'b1;
    logic       sclk  = 1'b0;
    logic       sdi   = 1'b0;
    logic       sdo;
    logic       sdo_oe;
    logic [6:0] reg_addr;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;

    logic [7:0] mem [128];
    int         wr_cnt   = 0;
    int         checks   = 0;
    int         failures = 0;
    int         oe_errs  = 0;
    bit         done     = 0;

    spi_regport uut (
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdi        (sdi),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .reg_addr   (reg_addr),
        .reg_wr_en  (reg_wr_en),
        .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data)
    );

    // register file model
    assign reg_rd_data = mem[reg_addr];
    always @(posedge sclk) begin
        if (reg_wr_en === 1'b1) begin
            mem[reg_addr] = reg_wr_data;
            wr_cnt++;
        end
    end

    function automatic logic [7:0] wval(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive nbits of a frame with 100 MHz serial clock; sclk idle low
    task automatic frame(input logic [6:0] a, input logic rd, input logic [7:0] wd,
                         input int nbits, input bit poke, output logic [7:0] rx);
        logic [15:0] bits;
        bits = {wd, rd, a};
        rx   = '0;
        for (int i = 0; i < nbits; i++) begin
            sdi = bits[i];
            #4;
            if (sdo_oe !== (rd && i >= 8)) oe_errs++;
            if (i >= 8) rx[i-8] = sdo;
            if (poke && i == 10) mem[a] = ~mem[a];
            #1 sclk = 1'b1;
            #5 sclk = 1'b0;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        logic [7:0] snap;
        int         base;
        for (int i = 0; i < 128; i++) mem[i] = 8'(i ^ 8'h5A);

        // R9: reset state
        #20;
        check(sdo_oe === 1'b0, "R9 sdo_oe in reset", int'(sdo_oe), 0);
        check(reg_wr_en === 1'b0, "R9 reg_wr_en in reset", int'(reg_wr_en), 0);

        // R8: full write frame while reset held
        cs_n = 1'b0; #10;
        frame(7'd5, 1'b0, 8'hC3, 16, 0, rx);
        cs_n = 1'b1; #10;
        check(wr_cnt == 0, "R8 no write in reset", wr_cnt, 0);
        check(mem[5] == 8'(5 ^ 8'h5A), "R8 reg unchanged", int'(mem[5]), 5 ^ 8'h5A);
        rst_n = 1'b1; #20;
        check(sdo_oe === 1'b0 && reg_wr_en === 1'b0, "R9 idle after reset", int'(sdo_oe), 0);

        // R3/R6: back-to-back write sweep under one select
        cs_n = 1'b0; #10;
        for (int a = 0; a < 128; a++) frame(7'(a), 1'b0, wval(a), 16, 0, rx);
        cs_n = 1'b1; #10;
        check(wr_cnt == 128, "R6 one strobe per frame", wr_cnt, 128);
        for (int a = 0; a < 128; a++)
            check(mem[a] == wval(a), "R3 write data", int'(mem[a]), int'(wval(a)));

        // R1/R4/R2: back-to-back read sweep
        oe_errs = 0;
        base    = wr_cnt;
        cs_n = 1'b0; #10;
        for (int a = 0; a < 128; a++) begin
            frame(7'(a), 1'b1, 8'hFF, 16, 0, rx);
            check(rx == wval(a), "R4 read data", int'(rx), int'(wval(a)));
        end
        cs_n = 1'b1; #10;
        check(wr_cnt == base, "R2 read frame never writes", wr_cnt - base, 0);
        check(oe_errs == 0, "R5 oe window", oe_errs, 0);

        // R6: write then read of same register in one select
        cs_n = 1'b0; #10;
        frame(7'd77, 1'b0, 8'h96, 16, 0, rx);
        frame(7'd77, 1'b1, 8'h00, 16, 0, rx);
        cs_n = 1'b1; #10;
        check(rx == 8'h96, "R6 write then read", int'(rx), 8'h96);

        // R4: register change after capture does not affect frame
        snap = mem[40];
        cs_n = 1'b0; #10;
        frame(7'd40, 1'b1, 8'h00, 16, 1, rx);
        cs_n = 1'b1; #10;
        check(rx == snap, "R4 snapshot", int'(rx), int'(snap));
        check(mem[40] == ~snap, "R4 poke landed", int'(mem[40]), int'(8'(~snap)));

        // R7: abort a write after every bit count 1..15
        for (int n = 1; n < 16; n++) begin
            base = wr_cnt;
            cs_n = 1'b0; #10;
            frame(7'd3, 1'b0, ~wval(3), n, 0, rx);
            cs_n = 1'b1; #1;
            check(sdo_oe === 1'b0, "R7 oe low after abort", int'(sdo_oe), 0);
            #9;
            check(wr_cnt == base, "R7 no write on abort", wr_cnt - base, 0);
        end
        cs_n = 1'b0; #10;
        frame(7'd3, 1'b1, 8'h00, 16, 0, rx);
        cs_n = 1'b1; #10;
        check(rx == wval(3), "R7 reg kept after aborts", int'(rx), int'(wval(3)));

        // R7: abort during read data phase, then fresh frame aligned
        oe_errs = 0;
        cs_n = 1'b0; #10;
        frame(7'd9, 1'b1, 8'h00, 12, 0, rx);
        #4;
        check(sdo_oe === 1'b1, "R5 oe in read data phase", int'(sdo_oe), 1);
        cs_n = 1'b1; #1;
        check(sdo_oe === 1'b0, "R7 oe drops on deselect", int'(sdo_oe), 0);
        #9;
        cs_n = 1'b0; #10;
        frame(7'd9, 1'b1, 8'h00, 16, 0, rx);
        cs_n = 1'b1; #10;
        check(rx == wval(9), "R7 next frame starts at bit 0", int'(rx), int'(wval(9)));
        check(oe_errs == 0, "R5 oe window after abort", oe_errs, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule